// File: doc/BRIEF.md
# Per-Flow Latency Bound Monitor

This block watches a set of independent traffic flows and checks that each transfer completes within its own cycle budget. Two strobes drive it. The first is a start strobe with a flow number, which arms that flow's timer. The second is an end strobe with a flow number, which closes the open transfer. Every flow owns a timer and a bound register. A flow whose timer passes its bound before the end strobe arrives is latched into a violation state. That state is reported on a per-flow flag and on a combined error line, and only a reset clears it.

The bound table is written through a small configuration port, one flow per cycle. For each flow the block keeps the largest latency seen among transfers that finished in time, and it can be read through a select input. An end strobe for a flow that has no open transfer changes no flow state and is counted in a saturating protocol-error counter. Each flow holds at most one open transfer at a time. A second start on an open flow restarts its measurement.

Top module: `lbm_latency_monitor`

## Requirements
- R1: After reset every flow is idle, all violation flags and the combined error output are 0, the protocol-error counter is 0, every recorded maximum is 0, and every bound holds its all-ones value.
- R2: A start strobe for an idle or open flow arms that flow and restarts its measurement. The latency of a transfer is the number of rising edges from the edge that samples its start to the edge that samples its end.
- R3: An end strobe for an open flow whose latency is at most that flow's bound closes the transfer without raising the flag, and the flow becomes idle again.
- R4: When an open flow reaches a latency of bound plus one with no accepted end, its violation flag is 1 after that edge. An end strobe sampled on that same edge does not prevent the violation. A bound of 0 therefore violates on the first edge after the start.
- R5: A violation flag is sticky. Later start or end strobes for that flow change neither the flag nor the recorded maximum, and they do not touch the protocol-error counter. Only reset clears the flag.
- R6: The combined error output is 1 exactly when at least one per-flow violation flag is 1.
- R7: An end strobe for an idle flow changes no flow state and adds one to the protocol-error counter. The counter stops at its all-ones value (255 with default widths).
- R8: Each flow's bound is written on its own through the configuration port (write enable, flow number, value). Flows run concurrently and are judged only against their own bound.
- R9: The timer saturates at its all-ones value instead of wrapping. With the all-ones bound a flow never violates, and a late completion records the saturated value as its latency.
- R10: For each flow the block records the largest latency of its transfers that completed in time, and presents it on the readout output for the flow number on the select input, combinationally.
- R11: When a start and an end strobe name the same idle or open flow in the same cycle, the start takes effect and the end is dropped without being counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Bound table write enable |
| cfgFlow | input | FLOW_W | Flow whose bound is written |
| cfgBound | input | TIMER_W | Bound value in cycles |
| startVld | input | 1 | Start strobe |
| startFlow | input | FLOW_W | Flow number of the start strobe |
| endVld | input | 1 | End strobe |
| endFlow | input | FLOW_W | Flow number of the end strobe |
| maxSelFlow | input | FLOW_W | Flow selected for maximum-latency readout |
| violFlags | output | NUM_FLOWS | Sticky per-flow violation flags |
| anyViol | output | 1 | OR of all violation flags |
| protoErrCnt | output | PERR_W | Saturating count of end strobes on idle flows |
| maxLatency | output | TIMER_W | Largest in-bound latency of the selected flow |

## Verification
A wrong internal state shows at the ports within the same transfer or the next one. A timer that counts off by one moves the violation edge, so the flag appears one cycle early or late against the bound-equals-latency and bound-plus-one cases. It also changes the recorded maximum of every completed transfer. A flow left open when it should be idle, or the reverse, shows on the next end strobe: the protocol counter moves when it should hold, or holds when it should move. A flag that drops or a timer that wraps shows as a cleared flag after later strobes, or as a small recorded maximum after a long transfer.

// File: rtl/lbm_pkg.sv
package lbm_pkg;

  typedef enum logic [1:0] {
    FLOW_IDLE = 2'd0,
    FLOW_OPEN = 2'd1,
    FLOW_VIOL = 2'd2
  } flowState_e;

  // Strobes from the control to one flow's datapath slice.
  typedef struct packed {
    logic clrTimer;   // restart the measurement
    logic runTimer;   // advance the timer this edge
    logic recordLat;  // transfer closed in time, update maximum
  } flowStrobe_t;

endpackage

// File: rtl/lbm_ctrl.sv
module lbm_ctrl
  import lbm_pkg::*;
#(
  parameter int NUM_FLOWS = 4,
  parameter int FLOW_W    = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startVld,
  input  logic [FLOW_W-1:0]     startFlow,
  input  logic                  endVld,
  input  logic [FLOW_W-1:0]     endFlow,
  input  logic [NUM_FLOWS-1:0]  overBound,
  output flowStrobe_t [NUM_FLOWS-1:0] strobes,
  output logic                  protoErr,
  output logic [NUM_FLOWS-1:0]  violFlags
);

  logic [NUM_FLOWS-1:0] idleEnd;

  for (genvar i = 0; i < NUM_FLOWS; i++) begin : g_flow
    flowState_e  stateQ, stateD;
    flowStrobe_t stb;
    logic        startHit, endHit, idleEndHit;

    assign startHit = startVld && (startFlow == FLOW_W'(i));
    assign endHit   = endVld && (endFlow == FLOW_W'(i));

    always_comb begin
      stateD     = stateQ;
      stb        = '0;
      idleEndHit = 1'b0;
      unique case (stateQ)
        FLOW_IDLE: begin
          if (startHit) begin
            stateD       = FLOW_OPEN;
            stb.clrTimer = 1'b1;
          end else if (endHit) begin
            idleEndHit = 1'b1;
          end
        end
        FLOW_OPEN: begin
          if (overBound[i]) begin
            stateD = FLOW_VIOL;
          end else if (startHit) begin
            stb.clrTimer = 1'b1;
          end else if (endHit) begin
            stateD        = FLOW_IDLE;
            stb.recordLat = 1'b1;
          end else begin
            stb.runTimer = 1'b1;
          end
        end
        FLOW_VIOL: stateD = FLOW_VIOL;
        default:   stateD = FLOW_IDLE;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rstN) stateQ <= FLOW_IDLE;
      else       stateQ <= stateD;
    end

    assign strobes[i]   = stb;
    assign idleEnd[i]   = idleEndHit;
    assign violFlags[i] = (stateQ == FLOW_VIOL);

    AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      violFlags[i] |=> violFlags[i]); // R5

    AST_VIOL_NEEDS_OVER: assert property (@(posedge clk) disable iff (!rstN)
      $rose(violFlags[i]) |-> $past(overBound[i])); // R4
  end

  assign protoErr = |idleEnd;

endmodule

// File: rtl/lbm_datapath.sv
module lbm_datapath
  import lbm_pkg::*;
#(
  parameter int NUM_FLOWS = 4,
  parameter int FLOW_W    = 2,
  parameter int TIMER_W   = 8,
  parameter int PERR_W    = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWe,
  input  logic [FLOW_W-1:0]     cfgFlow,
  input  logic [TIMER_W-1:0]    cfgBound,
  input  flowStrobe_t [NUM_FLOWS-1:0] strobes,
  input  logic                  protoErr,
  input  logic [FLOW_W-1:0]     maxSelFlow,
  output logic [NUM_FLOWS-1:0]  overBound,
  output logic [PERR_W-1:0]     protoErrCnt,
  output logic [TIMER_W-1:0]    maxLatency
);

  localparam logic [TIMER_W-1:0] TIMER_MAX = '1;
  localparam logic [PERR_W-1:0]  PERR_MAX  = '1;

  logic [TIMER_W-1:0] maxArr [NUM_FLOWS];

  for (genvar i = 0; i < NUM_FLOWS; i++) begin : g_slice
    logic [TIMER_W-1:0] boundQ, timerQ, maxQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        boundQ <= TIMER_MAX;
      end else if (cfgWe && (cfgFlow == FLOW_W'(i))) begin
        boundQ <= cfgBound;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        timerQ <= '0;
      end else if (strobes[i].clrTimer) begin
        timerQ <= TIMER_W'(1);
      end else if (strobes[i].runTimer && (timerQ != TIMER_MAX)) begin
        timerQ <= timerQ + TIMER_W'(1);
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        maxQ <= '0;
      end else if (strobes[i].recordLat && (timerQ > maxQ)) begin
        maxQ <= timerQ;
      end
    end

    assign overBound[i] = (timerQ > boundQ);
    assign maxArr[i]    = maxQ;

    AST_CLR_LOADS_ONE: assert property (@(posedge clk) disable iff (!rstN)
      strobes[i].clrTimer |=> (timerQ == TIMER_W'(1))); // R2

    AST_TIMER_SATURATES: assert property (@(posedge clk) disable iff (!rstN)
      (strobes[i].runTimer && (timerQ == TIMER_MAX)) |=> (timerQ == TIMER_MAX)); // R9

    AST_MAX_NEVER_FALLS: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> (maxQ >= $past(maxQ))); // R10
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      protoErrCnt <= '0;
    end else if (protoErr && (protoErrCnt != PERR_MAX)) begin
      protoErrCnt <= protoErrCnt + PERR_W'(1);
    end
  end

  always_comb begin
    maxLatency = '0;
    if (int'(maxSelFlow) < NUM_FLOWS) maxLatency = maxArr[maxSelFlow];
  end

  AST_PERR_NEVER_FALLS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (protoErrCnt >= $past(protoErrCnt))); // R7

endmodule

// File: rtl/lbm_latency_monitor.sv
module lbm_latency_monitor
  import lbm_pkg::*;
#(
  parameter int NUM_FLOWS = 4,
  parameter int TIMER_W   = 8,
  parameter int PERR_W    = 8,
  localparam int FLOW_W   = (NUM_FLOWS > 1) ? $clog2(NUM_FLOWS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic [FLOW_W-1:0]    cfgFlow,
  input  logic [TIMER_W-1:0]   cfgBound,
  input  logic                 startVld,
  input  logic [FLOW_W-1:0]    startFlow,
  input  logic                 endVld,
  input  logic [FLOW_W-1:0]    endFlow,
  input  logic [FLOW_W-1:0]    maxSelFlow,
  output logic [NUM_FLOWS-1:0] violFlags,
  output logic                 anyViol,
  output logic [PERR_W-1:0]    protoErrCnt,
  output logic [TIMER_W-1:0]   maxLatency
);

  flowStrobe_t [NUM_FLOWS-1:0] strobes;
  logic [NUM_FLOWS-1:0]        overBound;
  logic                        protoErr;

  lbm_ctrl #(
    .NUM_FLOWS(NUM_FLOWS),
    .FLOW_W   (FLOW_W)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .startVld (startVld),
    .startFlow(startFlow),
    .endVld   (endVld),
    .endFlow  (endFlow),
    .overBound(overBound),
    .strobes  (strobes),
    .protoErr (protoErr),
    .violFlags(violFlags)
  );

  lbm_datapath #(
    .NUM_FLOWS(NUM_FLOWS),
    .FLOW_W   (FLOW_W),
    .TIMER_W  (TIMER_W),
    .PERR_W   (PERR_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWe      (cfgWe),
    .cfgFlow    (cfgFlow),
    .cfgBound   (cfgBound),
    .strobes    (strobes),
    .protoErr   (protoErr),
    .maxSelFlow (maxSelFlow),
    .overBound  (overBound),
    .protoErrCnt(protoErrCnt),
    .maxLatency (maxLatency)
  );

  assign anyViol = |violFlags;

endmodule

// File: tb/lbm_latency_monitor_tb.sv
module lbm_latency_monitor_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWe = 1'b0;
  logic [1:0] cfgFlow = '0;
  logic [7:0] cfgBound = '0;
  logic       startVld = 1'b0;
  logic [1:0] startFlow = '0;
  logic       endVld = 1'b0;
  logic [1:0] endFlow = '0;
  logic [1:0] maxSelFlow = '0;
  logic [3:0] violFlags;
  logic       anyViol;
  logic [7:0] protoErrCnt;
  logic [7:0] maxLatency;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lbm_latency_monitor dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgFlow(cfgFlow), .cfgBound(cfgBound),
    .startVld(startVld), .startFlow(startFlow), .endVld(endVld), .endFlow(endFlow),
    .maxSelFlow(maxSelFlow), .violFlags(violFlags), .anyViol(anyViol),
    .protoErrCnt(protoErrCnt), .maxLatency(maxLatency)
  );

  typedef struct packed {
    logic [1:0] flow;
    logic [7:0] bound;
    logic [8:0] lat;
    logic       expViol;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 8'd5,  9'd3,  1'b0},   // R3 well inside
    '{2'd1, 8'd5,  9'd5,  1'b0},   // R3 latency equals bound
    '{2'd2, 8'd5,  9'd6,  1'b1},   // R4 end on the violating edge
    '{2'd3, 8'd0,  9'd1,  1'b1},   // R4 zero bound
    '{2'd1, 8'd1,  9'd1,  1'b0},   // R3 smallest latency
    '{2'd2, 8'd20, 9'd12, 1'b0},   // R3 longer bound
    '{2'd0, 8'd3,  9'd9,  1'b1}    // R4 far past bound
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
  endtask

  task automatic writeBound(input logic [1:0] f, input logic [7:0] b);
    cfgWe = 1'b1; cfgFlow = f; cfgBound = b;
    tick();
    cfgWe = 1'b0;
  endtask

  task automatic sendStart(input logic [1:0] f);
    startVld = 1'b1; startFlow = f;
    tick();
    startVld = 1'b0;
  endtask

  task automatic sendEnd(input logic [1:0] f);
    endVld = 1'b1; endFlow = f;
    tick();
    endVld = 1'b0;
  endtask

  // start sampled at edge e0, end sampled at edge e<lat>
  task automatic runFlow(input logic [1:0] f, input int lat);
    sendStart(f);
    repeat (lat - 1) tick();
    sendEnd(f);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog R1..all actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    tick();
    doReset();

    // R1 reset state
    chk("R1", "violFlags", violFlags, 0);
    chk("R1", "anyViol", anyViol, 0);
    chk("R1", "protoErrCnt", protoErrCnt, 0);
    for (int f = 0; f < 4; f++) begin
      maxSelFlow = 2'(f);
      #1 chk("R1", "maxLatency", maxLatency, 0);
    end
    // R1 default bound is all-ones: a 40-cycle transfer stays clean
    runFlow(2'd3, 40);
    maxSelFlow = 2'd3;
    #1;
    chk("R1", "default bound no violation", violFlags, 0);
    chk("R1", "default bound latency", maxLatency, 40);

    // Vector table: R3/R4/R10
    for (int v = 0; v < NVEC; v++) begin
      doReset();
      writeBound(VECS[v].flow, VECS[v].bound);
      runFlow(VECS[v].flow, int'(VECS[v].lat));
      maxSelFlow = VECS[v].flow;
      #1;
      chk(VECS[v].expViol ? "R4" : "R3", "flag", violFlags[VECS[v].flow], VECS[v].expViol);
      chk("R6", "anyViol", anyViol, VECS[v].expViol);
      chk("R10", "maxLatency", maxLatency, VECS[v].expViol ? 0 : 32'(VECS[v].lat));
      chk("R3", "protoErrCnt", protoErrCnt, 0);
    end

    // R3 flow returns idle: a further end is counted as protocol error
    doReset();
    writeBound(2'd0, 8'd5);
    runFlow(2'd0, 2);
    sendEnd(2'd0);
    chk("R3", "idle after close", protoErrCnt, 1);

    // R2 restart of an open flow
    doReset();
    writeBound(2'd1, 8'd5);
    sendStart(2'd1);
    repeat (3) tick();
    runFlow(2'd1, 3);
    maxSelFlow = 2'd1;
    #1;
    chk("R2", "restart no violation", violFlags[1], 0);
    chk("R2", "restart latency", maxLatency, 3);

    // R10 maximum tracking
    runFlow(2'd1, 4);
    runFlow(2'd1, 2);
    #1 chk("R10", "max keeps 4", maxLatency, 4);
    maxSelFlow = 2'd2;
    #1 chk("R10", "other flow untouched", maxLatency, 0);

    // R8 independent concurrent flows, R5 stickiness, R6 aggregate
    doReset();
    writeBound(2'd0, 8'd2);
    writeBound(2'd1, 8'd10);
    sendStart(2'd0);
    sendStart(2'd1);
    repeat (4) tick();
    chk("R8", "flow0 violated", violFlags[0], 1);
    chk("R8", "flow1 still clean", violFlags[1], 0);
    chk("R6", "anyViol with one flag", anyViol, 1);
    sendEnd(2'd1);
    maxSelFlow = 2'd1;
    #1;
    chk("R8", "flow1 closed clean", violFlags[1], 0);
    chk("R8", "flow1 latency", maxLatency, 5);
    sendStart(2'd0);
    repeat (2) tick();
    sendEnd(2'd0);
    maxSelFlow = 2'd0;
    #1;
    chk("R5", "flag sticky", violFlags, 4'b0001);
    chk("R5", "no counter on violated flow", protoErrCnt, 0);
    chk("R5", "max untouched", maxLatency, 0);
    doReset();
    chk("R5", "reset clears flag", violFlags, 0);

    // R7 idle end strobes and counter saturation
    sendEnd(2'd2);
    chk("R7", "one idle end", protoErrCnt, 1);
    chk("R7", "idle end no flag", violFlags, 0);
    endVld = 1'b1; endFlow = 2'd3;
    repeat (300) tick();
    endVld = 1'b0;
    chk("R7", "counter saturates", protoErrCnt, 255);

    // R9 timer saturation with all-ones bound
    doReset();
    writeBound(2'd2, 8'd255);
    runFlow(2'd2, 300);
    maxSelFlow = 2'd2;
    #1;
    chk("R9", "no violation at saturation", violFlags[2], 0);
    chk("R9", "saturated latency", maxLatency, 255);

    // R11 start and end for the same idle flow in one cycle
    doReset();
    writeBound(2'd3, 8'd6);
    startVld = 1'b1; startFlow = 2'd3; endVld = 1'b1; endFlow = 2'd3;
    tick();
    startVld = 1'b0; endVld = 1'b0;
    chk("R11", "end dropped", protoErrCnt, 0);
    tick();
    sendEnd(2'd3);
    maxSelFlow = 2'd3;
    #1;
    chk("R11", "start took effect", maxLatency, 2);
    chk("R11", "no violation", violFlags, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule